// File: doc/BRIEF.md
# Branch and skip decision unit

This unit decides whether a control-flow operation sends the program counter somewhere other than the next sequential word. It handles two families of operation. Conditional relative branches test one status flag, or the signed-order term N XOR V. Skip operations step over the following instruction when two register operands are equal, or when a chosen operand bit is in the wanted state. For each request the unit returns a taken flag, the next PC and the number of cycles the operation costs.

A decode stage raises `valid_i` for one cycle and supplies the operation kind, the condition selector, the operands, the signed offset, the current PC and whether the next instruction is two words long. The result is registered. It appears with `done_o` on the following cycle and is held until the next request. The PC is a plain binary word that wraps modulo 2^PC_W.

Top module: `branch_skip_unit`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `taken_o`, `next_pc_o` and `cycles_o` are all zero.
- R2: A request accepted with `valid_i` high at a clock edge is reported in the cycle after it, with `done_o` high. In a cycle after an edge where `valid_i` was low, `done_o` is low and `taken_o`, `next_pc_o` and `cycles_o` keep their previous values.
- R3: The kind code on `kind_i` is 0 for a branch, 1 for skip-if-equal, 2 for skip-on-bit and 3 for a pass operation. For kind 0 with `signed_i` low, the operation is taken exactly when `flags_i[sel_i]` equals `sense_i`. Here `sense_i` = 1 means "branch if set" and 0 means "branch if clear".
- R4: For kind 0 with `signed_i` high, the tested value is `flags_i[2]` XOR `flags_i[3]`, where bit 2 is N and bit 3 is V, and `sel_i` is ignored. With `sense_i` = 0 the operation is a signed greater-or-equal, taken when the XOR is 0. With `sense_i` = 1 it is a signed less-than, taken when the XOR is 1.
- R5: A taken branch gives `next_pc_o` = `pc_i` + sign-extended `offset_i` + 1. Here `offset_i` is OFS_W-bit two's complement. A branch that is not taken gives `pc_i` + 1.
- R6: A branch that is not taken costs 1 cycle, and a taken branch costs 2 cycles.
- R7: For kind 1, the operation is taken exactly when `opa_i` equals `opb_i`, whatever the values of `sel_i` and `sense_i`.
- R8: For kind 2, the operation is taken exactly when `opa_i[sel_i]` equals `sense_i`.
- R9: A skip that is not taken costs 1 cycle and gives `pc_i` + 1. When `two_word_i` is low, a taken skip costs 2 cycles and gives `pc_i` + 2. When `two_word_i` is high, it costs 3 cycles and gives `pc_i` + 3. Skips ignore `offset_i`.
- R10: Kind 3 is never taken. It gives `pc_i` + 1 and costs 1 cycle.
- R11: All PC arithmetic wraps modulo 2^PC_W, both forward past the top and backward below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| kind_i | input | 2 | Operation kind: 0 branch, 1 skip-if-equal, 2 skip-on-bit, 3 pass |
| flags_i | input | 8 | Status flags: C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7 |
| sel_i | input | 3 | Flag index for a branch, operand bit index for a skip-on-bit |
| sense_i | input | 1 | 1 = taken when the bit is set, 0 = taken when it is clear |
| signed_i | input | 1 | Branch tests N XOR V instead of a selected flag |
| opa_i | input | 8 | First register operand |
| opb_i | input | 8 | Second register operand, used for equality |
| offset_i | input | OFS_W | Signed relative branch offset |
| pc_i | input | PC_W | Current PC |
| two_word_i | input | 1 | The instruction after a skip is two words long |
| done_o | output | 1 | A result is present this cycle |
| taken_o | output | 1 | The PC is redirected |
| next_pc_o | output | PC_W | Next PC |
| cycles_o | output | 2 | Cycles consumed: 1, 2 or 3 |

## Verification
The assertions check several properties on every cycle. They check the one-cycle result timing and the holding of results between requests. They check that the signed branch follows N XOR V. They check that a branch that is not taken lands on PC + 1. They check that a skip always advances the PC by exactly its cycle count, and that the pass kind never redirects. The bench's scenarios cover the rest: the exact branch target for chosen offsets and wrap points, every flag index and sense over all 256 flag patterns, equality against near-miss operands, and bit-skips over every bit position. These depend on the specific values being computed rather than on a relation between ports.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned OPD_W  = 1 << SEL_W;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_V = 3;
  localparam int unsigned CYC_W  = 2;

  typedef enum logic [1:0] {
    KIND_BRANCH   = 2'd0,
    KIND_SKIP_EQ  = 2'd1,
    KIND_SKIP_BIT = 2'd2,
    KIND_PASS     = 2'd3
  } kind_e;

  typedef struct packed {
    logic             taken;
    logic [CYC_W-1:0] cycles;
  } decision_t;
endpackage

// File: rtl/bsu_cond.sv
module bsu_cond
  import bsu_pkg::*;
(
  input  kind_e              kind_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               sense_i,
  input  logic               signed_i,
  input  logic [OPD_W-1:0]   opa_i,
  input  logic [OPD_W-1:0]   opb_i,
  output logic               taken_o
);
  logic flag_bit;
  logic opd_bit;

  // signed order uses N^V, not a stored flag
  assign flag_bit = signed_i ? (flags_i[FLAG_N] ^ flags_i[FLAG_V]) : flags_i[sel_i];
  assign opd_bit  = opa_i[sel_i];

  always_comb begin
    unique case (kind_i)
      KIND_BRANCH:   taken_o = (flag_bit == sense_i);
      KIND_SKIP_EQ:  taken_o = (opa_i == opb_i);
      KIND_SKIP_BIT: taken_o = (opd_bit == sense_i);
      default:       taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsu_target.sv
module bsu_target
  import bsu_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 7
) (
  input  kind_e              kind_i,
  input  logic               taken_i,
  input  logic               two_word_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [OFS_W-1:0]   offset_i,
  output logic [PC_W-1:0]    next_pc_o,
  output decision_t          dec_o
);
  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] branch_pc;
  logic [PC_W-1:0] step_pc;

  generate
    if (PC_W > OFS_W) begin : g_sext
      assign ofs_ext = {{(PC_W-OFS_W){offset_i[OFS_W-1]}}, offset_i};
    end else begin : g_trunc
      assign ofs_ext = offset_i[PC_W-1:0];
    end
  endgenerate

  assign branch_pc = pc_i + ofs_ext + PC_W'(1);

  always_comb begin
    dec_o.taken  = taken_i;
    dec_o.cycles = CYC_W'(1);
    if (taken_i) begin
      if (kind_i == KIND_BRANCH) dec_o.cycles = CYC_W'(2);
      else                       dec_o.cycles = two_word_i ? CYC_W'(3) : CYC_W'(2);
    end
  end

  // a skip advances by exactly its cycle count
  assign step_pc   = pc_i + PC_W'(dec_o.cycles);
  assign next_pc_o = (taken_i && kind_i == KIND_BRANCH) ? branch_pc : step_pc;
endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
  import bsu_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic [7:0]        flags_i,
  input  logic [2:0]        sel_i,
  input  logic              sense_i,
  input  logic              signed_i,
  input  logic [7:0]        opa_i,
  input  logic [7:0]        opb_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              two_word_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [1:0]        cycles_o
);
  kind_e           kind;
  logic            taken_c;
  logic [PC_W-1:0] next_pc_c;
  decision_t       dec_c;

  assign kind = kind_e'(kind_i);

  bsu_cond u_cond (
    .kind_i   (kind),
    .flags_i  (flags_i),
    .sel_i    (sel_i),
    .sense_i  (sense_i),
    .signed_i (signed_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .taken_o  (taken_c)
  );

  bsu_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
    .kind_i     (kind),
    .taken_i    (taken_c),
    .two_word_i (two_word_i),
    .pc_i       (pc_i),
    .offset_i   (offset_i),
    .next_pc_o  (next_pc_c),
    .dec_o      (dec_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      cycles_o  <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        taken_o   <= dec_c.taken;
        next_pc_o <= next_pc_c;
        cycles_o  <= dec_c.cycles;
      end
    end
  end
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int unsigned PC_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [1:0]      kind_i,
  input logic [7:0]      flags_i,
  input logic            sense_i,
  input logic            signed_i,
  input logic [PC_W-1:0] pc_i,
  input logic            two_word_i,
  input logic            done_o,
  input logic            taken_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic [1:0]      cycles_o
);
  always_comb begin
    if (!rst_ni) begin
      a_reset_r1: assert (!done_o && !taken_o && next_pc_o == '0 && cycles_o == 2'd0);
    end
  end

  p_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!done_o && $stable(taken_o) && $stable(next_pc_o) && $stable(cycles_o)));

  p_signed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'd0 && signed_i) |=>
      (taken_o == (($past(flags_i[2]) ^ $past(flags_i[3])) == $past(sense_i))));

  p_not_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (taken_o || (next_pc_o == $past(pc_i) + PC_W'(1) && cycles_o == 2'd1)));

  p_branch_cyc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'd0) |=> (cycles_o == (taken_o ? 2'd2 : 2'd1)));

  p_skip_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind_i == 2'd1 || kind_i == 2'd2)) |=>
      (next_pc_o == $past(pc_i) + PC_W'(cycles_o)));

  p_skip_cyc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind_i == 2'd1 || kind_i == 2'd2)) |=>
      (cycles_o == (!taken_o ? 2'd1 : ($past(two_word_i) ? 2'd3 : 2'd2))));

  p_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'd3) |=> !taken_o);
endmodule

bind branch_skip_unit bsu_checker #(.PC_W(PC_W)) u_bsu_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .kind_i     (kind_i),
  .flags_i    (flags_i),
  .sense_i    (sense_i),
  .signed_i   (signed_i),
  .pc_i       (pc_i),
  .two_word_i (two_word_i),
  .done_o     (done_o),
  .taken_o    (taken_o),
  .next_pc_o  (next_pc_o),
  .cycles_o   (cycles_o)
);

// File: tb/branch_skip_unit_tb_top.sv
`timescale 1ns/1ps
module branch_skip_unit_tb_top;
  localparam int PC_W  = 16;
  localparam int OFS_W = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             valid;
  logic [1:0]       kind;
  logic [7:0]       flags;
  logic [2:0]       sel;
  logic             sense;
  logic             sgn;
  logic [7:0]       opa, opb;
  logic [OFS_W-1:0] offset;
  logic [PC_W-1:0]  pc;
  logic             two_word;
  logic             done, taken;
  logic [PC_W-1:0]  next_pc;
  logic [1:0]       cycles;

  branch_skip_unit #(.PC_W(PC_W), .OFS_W(OFS_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .kind_i(kind), .flags_i(flags),
    .sel_i(sel), .sense_i(sense), .signed_i(sgn), .opa_i(opa), .opb_i(opb),
    .offset_i(offset), .pc_i(pc), .two_word_i(two_word), .done_o(done),
    .taken_o(taken), .next_pc_o(next_pc), .cycles_o(cycles)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic            e_done = 1'b0, e_taken = 1'b0;
  logic [PC_W-1:0] e_pc = '0;
  logic [1:0]      e_cyc = '0;

  task automatic compare(input string tag);
    n_cmp++;
    if (done !== e_done || taken !== e_taken || next_pc !== e_pc || cycles !== e_cyc) begin
      n_bad++;
      $display("FAIL %s: actual done=%0b taken=%0b pc=%h cyc=%0d expected done=%0b taken=%0b pc=%h cyc=%0d",
               tag, done, taken, next_pc, cycles, e_done, e_taken, e_pc, e_cyc);
    end
  endtask

  // behavioural reference of one request
  task automatic model(input logic [1:0] k, input logic [7:0] f, input logic [2:0] s,
                       input logic sn, input logic sg, input logic [7:0] a, input logic [7:0] b,
                       input logic [OFS_W-1:0] o, input logic [PC_W-1:0] p, input logic tw);
    bit t;
    int off, adv;
    case (k)
      2'd0: t = ((sg ? (f[2] ^ f[3]) : f[s]) == sn);
      2'd1: t = (a == b);
      2'd2: t = (a[s] == sn);
      default: t = 0;
    endcase
    off = int'(o);
    if (off >= (1 << (OFS_W-1))) off -= (1 << OFS_W);
    if (!t) begin adv = 1; e_cyc = 2'd1; end
    else if (k == 2'd0) begin adv = off + 1; e_cyc = 2'd2; end
    else begin adv = tw ? 3 : 2; e_cyc = tw ? 2'd3 : 2'd2; end
    e_taken = t;
    e_pc = PC_W'((int'(p) + adv) & ((1 << PC_W) - 1));
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic [7:0] f,
                      input logic [2:0] s, input logic sn, input logic sg,
                      input logic [7:0] a, input logic [7:0] b, input logic [OFS_W-1:0] o,
                      input logic [PC_W-1:0] p, input logic tw, input string tag);
    @(negedge clk);
    valid = v; kind = k; flags = f; sel = s; sense = sn; sgn = sg;
    opa = a; opb = b; offset = o; pc = p; two_word = tw;
    if (v) model(k, f, s, sn, sg, a, b, o, p, tw);
    e_done = v;
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic idle(input logic [PC_W-1:0] junk_pc);
    step(1'b0, 2'd1, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, '0, junk_pc, 1'b1, "R2");
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL R2: watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; kind = '0; flags = '0; sel = '0; sense = 1'b0; sgn = 1'b0;
    opa = '0; opb = '0; offset = '0; pc = 16'h1234; two_word = 1'b0;
    repeat (3) @(posedge clk);
    valid = 1'b1;
    @(negedge clk);
    compare("R1");
    valid = 1'b0;
    rst_n = 1'b1;

    // R3: every flag index and sense over all flag patterns
    for (int f = 0; f < 256; f++) begin
      for (int c = 0; c < 16; c++)
        step(1'b1, 2'd0, f[7:0], c[2:0], c[3], 1'b0, 8'h00, 8'h00,
             OFS_W'(f + c * 9), PC_W'(f * 257 + c), c[0], "R3");
      idle(PC_W'(f));
    end
    // R4: signed greater-or-equal / less-than over all flag patterns
    for (int f = 0; f < 256; f++)
      for (int c = 0; c < 2; c++)
        step(1'b1, 2'd0, f[7:0], 3'(f), c[0], 1'b1, 8'h00, 8'h00,
             OFS_W'(f), PC_W'(16'h8000 + f), 1'b0, "R4");

    // R5/R6: target extremes
    step(1'b1, 2'd0, 8'h01, 3'd0, 1'b1, 1'b0, 8'h00, 8'h00, 7'h3F, 16'h1000, 1'b0, "R5");
    step(1'b1, 2'd0, 8'h01, 3'd0, 1'b1, 1'b0, 8'h00, 8'h00, 7'h40, 16'h1000, 1'b0, "R5");
    step(1'b1, 2'd0, 8'h01, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, 7'h40, 16'h1000, 1'b0, "R6");
    step(1'b1, 2'd0, 8'h02, 3'd1, 1'b1, 1'b0, 8'h00, 8'h00, 7'h7F, 16'h0020, 1'b0, "R6");
    // R11: wrap both ways
    step(1'b1, 2'd0, 8'h01, 3'd0, 1'b1, 1'b0, 8'h00, 8'h00, 7'h00, 16'hFFFF, 1'b0, "R11");
    step(1'b1, 2'd0, 8'h01, 3'd0, 1'b1, 1'b0, 8'h00, 8'h00, 7'h40, 16'h0000, 1'b0, "R11");
    step(1'b1, 2'd1, 8'h00, 3'd0, 1'b0, 1'b0, 8'h5A, 8'h5A, 7'h00, 16'hFFFE, 1'b1, "R11");
    step(1'b1, 2'd2, 8'h00, 3'd7, 1'b0, 1'b0, 8'h00, 8'h00, 7'h00, 16'hFFFF, 1'b0, "R11");

    // R7: equality skip, sense and selector must not matter
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 2'd1, 8'hFF, 3'(i), i[0], 1'b0, 8'(i * 37), 8'(i * 37), 7'h05, PC_W'(i * 100), i[1], "R7");
      step(1'b1, 2'd1, 8'hFF, 3'(i), i[0], 1'b0, 8'(i * 37), 8'(i * 37) ^ (8'h1 << i), 7'h05, PC_W'(i * 100), i[1], "R7");
    end
    // R8/R9: bit skip, every position and sense, both next-instruction lengths
    for (int i = 0; i < 32; i++)
      step(1'b1, 2'd2, 8'h00, 3'(i), i[3], 1'b0, 8'hA5 ^ 8'(i >> 4), 8'h00, 7'h33,
           PC_W'(16'h4000 + i), i[4], i[4] ? "R9" : "R8");
    step(1'b1, 2'd1, 8'h00, 3'd0, 1'b0, 1'b0, 8'h11, 8'h11, 7'h3F, 16'h2000, 1'b0, "R9");
    step(1'b1, 2'd1, 8'h00, 3'd0, 1'b0, 1'b0, 8'h11, 8'h11, 7'h3F, 16'h2000, 1'b1, "R9");
    step(1'b1, 2'd1, 8'h00, 3'd0, 1'b0, 1'b0, 8'h11, 8'h12, 7'h3F, 16'h2000, 1'b1, "R9");
    idle(16'hBEEF);

    // R10: pass kind never redirects
    for (int i = 0; i < 8; i++)
      step(1'b1, 2'd3, 8'(i * 31), 3'(i), i[0], i[1], 8'h33, 8'h33, 7'h3F, PC_W'(i * 4099), i[2], "R10");
    idle(16'h0000);
    idle(16'h7777);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule